// File: doc/BRIEF.md
# Thermal Sensor Sampling Controller

This block schedules temperature measurements on up to four on-die sensors and makes the results readable through a small 32-bit word-addressed register interface. A period timer starts a measurement round at a programmable interval. In each round the controller walks the enabled sensors in ascending index order. For each sensor it holds an acquire phase, then issues a one-cycle conversion request to the sensor front end, then waits for the returned 12-bit code.

Codes go either straight into the sensor's data register or through an averaging filter. The filter sums a power-of-two number of codes and shifts the sum right. Each stored result sets that sensor's status bit. The interrupt line is raised for every status bit whose interrupt enable is set. Software clears a status bit by writing a one to it.

The analog sensor and converter are outside the block. A front end returns a code with a done strobe some cycles after each request.

Top module: `ths_sampler`

## Requirements
- R1: After reset every register reads zero, and `acq_o`, `start_o` and `irq_o` are low.
- R2: Control word bits [15:0] hold the acquire length minus one. `acq_o` stays high for exactly that field plus one cycles. It is followed at once by a single-cycle `start_o` pulse, and `sel_o` is held during the whole phase.
- R3: Control word bits [31:16] hold the slot length minus one. Within a round, consecutive acquire phases begin exactly field plus one cycles apart when the conversion finishes earlier.
- R4: The period register field in bits [31:12] sets the round interval to (field + 1) × 2^UNIT_W clocks, with UNIT_W = 12 by default (4096 clocks). The interval applies per filter sample, and the timer restarts whenever no sensor is enabled.
- R5: The sensor enable register (offset 0x04, bit i = sensor i) selects the sensors. Enabled sensors are converted in ascending index order. A disabled sensor is never requested, and its data register keeps its value.
- R6: Sensor i's data is read at offset 0x20 + 4·i in bits [11:0]. It reads zero until that sensor's first result has been stored.
- R7: With filter bit 2 clear (filter register at offset 0x0C), each returned code is stored unchanged.
- R8: With filter bit 2 set, type t in bits [1:0] averages 2^(t+1) codes; type 1 averages 4. The data register is updated and the status bit set only on the last code of a group, with the sum shifted right by t+1. Writing the filter register restarts all groups.
- R9: The status register at offset 0x14 sets bit i on each stored result for sensor i. Writing a 1 clears only that bit, and writing 0 has no effect.
- R10: A result arriving while a status bit is already set leaves it set, and no second event is queued: one clear leaves the bit at zero.
- R11: `irq_o` is high exactly when some status bit and the matching bit of the interrupt enable register (offset 0x10) are both set.
- R12: Control (0x00), enable, interrupt enable and period read back as written within their fields. The filter register reads bits [2:0], and an unmapped word reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Byte address of the register word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| acq_o | output | 1 | Acquire phase active for sensor `sel_o` |
| start_o | output | 1 | One-cycle conversion request |
| sel_o | output | 2 | Index of the sensor being measured |
| done_i | input | 1 | Front end: conversion result valid |
| code_i | input | 12 | Front end: raw conversion code |
| irq_o | output | 1 | Data-ready interrupt |

## Verification
The hardest state to reach is an averaging group caught part-way: some codes have been accumulated, yet the data register and status bit must still show nothing new. The bench gets there by enabling a single sensor with the filter on. It counts acquire phases on the ports and reads the status register after the last-but-one code of a group has returned but before the next round can begin. A small period unit makes rounds 32 clocks long, so every ordering, skip and filter depth is reached within a few hundred cycles.

// File: rtl/ths_pkg.sv
package ths_pkg;
  localparam int unsigned CODE_W = 12;
  localparam int unsigned PER_W  = 20;
  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_EN   = 8'h04;
  localparam logic [7:0] OFS_PER  = 8'h08;
  localparam logic [7:0] OFS_FLT  = 8'h0C;
  localparam logic [7:0] OFS_IE   = 8'h10;
  localparam logic [7:0] OFS_STS  = 8'h14;
  localparam logic [7:0] OFS_DATA = 8'h20;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_ACQ, SQ_CONV, SQ_WAIT, SQ_HOLD
  } sq_state_e;
endpackage

// File: rtl/ths_timer.sv
module ths_timer #(
  parameter int unsigned UNIT_W = 12,
  parameter int unsigned PER_W  = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PER_W-1:0] field_i,
  output logic             tick_o
);
  logic [UNIT_W-1:0] unit_q;
  logic [PER_W-1:0]  per_q;
  logic              unit_end, per_end;

  assign unit_end = &unit_q;
  assign per_end  = per_q >= field_i;
  assign tick_o   = run_i && unit_end && per_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unit_q <= '0;
      per_q  <= '0;
    end else if (!run_i) begin
      unit_q <= '0;
      per_q  <= '0;
    end else begin
      unit_q <= unit_q + 1'b1;
      if (unit_end) per_q <= per_end ? '0 : per_q + 1'b1;
    end
  end
endmodule

// File: rtl/ths_seq.sv
module ths_seq
  import ths_pkg::*;
#(
  parameter int unsigned N_SENS = 4,
  parameter int unsigned IDX_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [N_SENS-1:0] en_i,
  input  logic [15:0]       acq_len_i,
  input  logic [15:0]       slot_len_i,
  input  logic              done_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              acq_o,
  output logic              start_o,
  output logic [IDX_W-1:0]  sel_o,
  output logic              res_vld_o,
  output logic [IDX_W-1:0]  res_idx_o,
  output logic [CODE_W-1:0] res_code_o
);
  sq_state_e        state_q;
  logic [IDX_W-1:0] idx_q, nxt;
  logic [IDX_W:0]   from;
  logic [15:0]      cnt_q, cnt_inc;
  logic             found;

  assign from    = (state_q == SQ_IDLE) ? '0 : {1'b0, idx_q} + 1'b1;
  assign cnt_inc = (&cnt_q) ? cnt_q : cnt_q + 1'b1;

  // lowest enabled sensor at or above 'from'
  always_comb begin
    found = 1'b0;
    nxt   = '0;
    for (int i = N_SENS - 1; i >= 0; i--) begin
      if (en_i[i] && ((IDX_W+1)'(i) >= from)) begin
        found = 1'b1;
        nxt   = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        SQ_IDLE: if (tick_i && found) begin
          state_q <= SQ_ACQ;
          idx_q   <= nxt;
          cnt_q   <= '0;
        end
        SQ_ACQ: begin
          cnt_q <= cnt_inc;
          if (cnt_q == acq_len_i) state_q <= SQ_CONV;
        end
        SQ_CONV: begin
          cnt_q   <= cnt_inc;
          state_q <= SQ_WAIT;
        end
        SQ_WAIT: begin
          cnt_q <= cnt_inc;
          if (done_i) state_q <= SQ_HOLD;
        end
        SQ_HOLD: begin
          cnt_q <= cnt_inc;
          if (cnt_q >= slot_len_i) begin
            if (found) begin
              state_q <= SQ_ACQ;
              idx_q   <= nxt;
              cnt_q   <= '0;
            end else begin
              state_q <= SQ_IDLE;
            end
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign acq_o      = state_q == SQ_ACQ;
  assign start_o    = state_q == SQ_CONV;
  assign sel_o      = idx_q;
  assign res_vld_o  = (state_q == SQ_WAIT) && done_i;
  assign res_idx_o  = idx_q;
  assign res_code_o = code_i;
endmodule

// File: rtl/ths_filter.sv
module ths_filter
  import ths_pkg::*;
#(
  parameter int unsigned N_SENS = 4,
  parameter int unsigned IDX_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [1:0]        type_i,
  input  logic              vld_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [N_SENS-1:0] out_vld_o,
  output logic [CODE_W-1:0] out_code_o
);
  localparam int unsigned ACC_W = CODE_W + 4;

  logic [N_SENS*ACC_W-1:0] acc_flat;
  logic [3:0]              last_cnt;
  logic [ACC_W-1:0]        sel_sum, shifted;

  always_comb begin
    unique case (type_i)
      2'd0:    last_cnt = 4'd1;
      2'd1:    last_cnt = 4'd3;
      2'd2:    last_cnt = 4'd7;
      default: last_cnt = 4'd15;
    endcase
  end

  for (genvar g = 0; g < N_SENS; g++) begin : g_acc
    logic [ACC_W-1:0] acc_q;
    logic [3:0]       n_q;
    logic             hit, last;
    assign hit  = vld_i && (idx_i == IDX_W'(g));
    assign last = n_q == last_cnt;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        acc_q <= '0;
        n_q   <= '0;
      end else if (clr_i) begin
        acc_q <= '0;
        n_q   <= '0;
      end else if (hit && en_i) begin
        acc_q <= last ? '0 : acc_q + ACC_W'(code_i);
        n_q   <= last ? '0 : n_q + 1'b1;
      end
    end
    assign acc_flat[g*ACC_W +: ACC_W] = acc_q;
    assign out_vld_o[g] = hit && (!en_i || last);
  end

  assign sel_sum    = acc_flat[idx_i*ACC_W +: ACC_W] + ACC_W'(code_i);
  assign shifted    = sel_sum >> ({1'b0, type_i} + 3'd1);
  assign out_code_o = en_i ? shifted[CODE_W-1:0] : code_i;
endmodule

// File: rtl/ths_sampler.sv
module ths_sampler
  import ths_pkg::*;
#(
  parameter int unsigned N_SENS = 4,
  parameter int unsigned UNIT_W = 12,
  localparam int unsigned IDX_W = (N_SENS > 1) ? $clog2(N_SENS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [7:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              acq_o,
  output logic              start_o,
  output logic [IDX_W-1:0]  sel_o,
  input  logic              done_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              irq_o
);
  logic [31:0]              ctrl_q;
  logic [N_SENS-1:0]        en_q, ie_q, sts_q, flt_vld, clr_m;
  logic [PER_W-1:0]         per_q;
  logic                     flt_en_q;
  logic [1:0]               flt_type_q;
  logic [N_SENS*CODE_W-1:0] data_flat;
  logic                     tick, res_vld;
  logic [IDX_W-1:0]         res_idx;
  logic [CODE_W-1:0]        res_code, flt_code;
  logic                     wr_ctrl, wr_en, wr_per, wr_flt, wr_ie, wr_sts;
  logic [5:0]               wi;

  assign wi      = addr_i[7:2];
  assign wr_ctrl = we_i && wi == OFS_CTRL[7:2];
  assign wr_en   = we_i && wi == OFS_EN[7:2];
  assign wr_per  = we_i && wi == OFS_PER[7:2];
  assign wr_flt  = we_i && wi == OFS_FLT[7:2];
  assign wr_ie   = we_i && wi == OFS_IE[7:2];
  assign wr_sts  = we_i && wi == OFS_STS[7:2];
  assign clr_m   = wr_sts ? wdata_i[N_SENS-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= '0;
      en_q       <= '0;
      per_q      <= '0;
      flt_en_q   <= 1'b0;
      flt_type_q <= '0;
      ie_q       <= '0;
      sts_q      <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata_i;
      if (wr_en)   en_q   <= wdata_i[N_SENS-1:0];
      if (wr_per)  per_q  <= wdata_i[31:12];
      if (wr_flt) begin
        flt_en_q   <= wdata_i[2];
        flt_type_q <= wdata_i[1:0];
      end
      if (wr_ie)   ie_q   <= wdata_i[N_SENS-1:0];
      sts_q <= (sts_q & ~clr_m) | flt_vld;  // new result wins over clear
    end
  end

  for (genvar g = 0; g < N_SENS; g++) begin : g_data
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         data_flat[g*CODE_W +: CODE_W] <= '0;
      else if (flt_vld[g]) data_flat[g*CODE_W +: CODE_W] <= flt_code;
    end
  end

  ths_timer #(.UNIT_W(UNIT_W), .PER_W(PER_W)) i_timer (
    .clk_i, .rst_ni, .run_i(|en_q), .field_i(per_q), .tick_o(tick)
  );

  ths_seq #(.N_SENS(N_SENS), .IDX_W(IDX_W)) i_seq (
    .clk_i, .rst_ni, .tick_i(tick), .en_i(en_q),
    .acq_len_i(ctrl_q[15:0]), .slot_len_i(ctrl_q[31:16]),
    .done_i, .code_i, .acq_o, .start_o, .sel_o,
    .res_vld_o(res_vld), .res_idx_o(res_idx), .res_code_o(res_code)
  );

  ths_filter #(.N_SENS(N_SENS), .IDX_W(IDX_W)) i_filter (
    .clk_i, .rst_ni, .clr_i(wr_flt), .en_i(flt_en_q), .type_i(flt_type_q),
    .vld_i(res_vld), .idx_i(res_idx), .code_i(res_code),
    .out_vld_o(flt_vld), .out_code_o(flt_code)
  );

  always_comb begin
    rdata_o = '0;
    unique case (wi)
      OFS_CTRL[7:2]: rdata_o = ctrl_q;
      OFS_EN[7:2]:   rdata_o = 32'(en_q);
      OFS_PER[7:2]:  rdata_o = {per_q, 12'b0};
      OFS_FLT[7:2]:  rdata_o = {29'b0, flt_en_q, flt_type_q};
      OFS_IE[7:2]:   rdata_o = 32'(ie_q);
      OFS_STS[7:2]:  rdata_o = 32'(sts_q);
      default: begin
        for (int g = 0; g < N_SENS; g++) begin
          if (wi == OFS_DATA[7:2] + 6'(g)) rdata_o = 32'(data_flat[g*CODE_W +: CODE_W]);
        end
      end
    endcase
  end

  assign irq_o = |(sts_q & ie_q);
endmodule

// File: rtl/ths_sampler_chk.sv
module ths_sampler_chk
  import ths_pkg::*;
#(
  parameter int unsigned N_SENS = 4,
  parameter int unsigned IDX_W  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [7:0]        addr_i,
  input logic [31:0]       wdata_i,
  input logic              acq_o,
  input logic              start_o,
  input logic [IDX_W-1:0]  sel_o,
  input logic              irq_o,
  input logic [N_SENS-1:0] en_q,
  input logic [N_SENS-1:0] ie_q,
  input logic [N_SENS-1:0] sts_q,
  input logic [N_SENS-1:0] flt_vld
);
  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);  // R2
  AST_ACQ_BEFORE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(acq_o));  // R2
  AST_SEL_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acq_o && $past(acq_o)) |-> $stable(sel_o));  // R2
  AST_SEL_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(acq_o) |-> (($past(en_q) & (N_SENS'(1) << sel_o)) != '0));  // R5
  AST_STS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|flt_vld) |=> ((sts_q & $past(flt_vld)) == $past(flt_vld)));  // R9
  AST_STS_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFS_STS && flt_vld == '0) |=> ((sts_q & $past(wdata_i[N_SENS-1:0])) == '0));  // R9
  AST_IRQ_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ie_q == '0) |-> !irq_o);  // R11
endmodule

bind ths_sampler ths_sampler_chk #(.N_SENS(N_SENS), .IDX_W(IDX_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .acq_o(acq_o), .start_o(start_o), .sel_o(sel_o), .irq_o(irq_o),
  .en_q(en_q), .ie_q(ie_q), .sts_q(sts_q), .flt_vld(flt_vld)
);

// File: tb/test_ths_sampler.sv
module test_ths_sampler;
  localparam int ACQ_F = 2, SLOT_F = 20, PER_F = 3, UNIT_W = 3;
  localparam int ROUND = (PER_F + 1) << UNIT_W;

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0, done = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic acq, start, irq;
  logic [1:0] sel;
  logic [11:0] code = '0;

  int checks = 0, failures = 0, cyc = 0;
  int log_n = 0;
  int log_sel [32];
  int log_t [32];
  int acq_run = 0;
  logic acq_prev = 1'b0;
  int pend = 0, pend_sel = 0;
  int conv_n [4], exp_d [4], grp_sum [4], grp_n [4];
  logic m_en = 1'b0;
  int m_t = 0;
  logic [31:0] rv, keep1;

  ths_sampler #(.N_SENS(4), .UNIT_W(UNIT_W)) i_ths_sampler (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .acq_o(acq), .start_o(start), .sel_o(sel),
    .done_i(done), .code_i(code), .irq_o(irq)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // front end model, acquire monitor and expected data
  always @(negedge clk) begin
    done = 1'b0;
    if (pend != 0) begin
      pend--;
      if (pend == 0) begin
        int s, c;
        s = pend_sel;
        c = (s * 700 + conv_n[s] * 113 + 9) % 4096;
        conv_n[s]++;
        done = 1'b1;
        code = 12'(c);
        if (!m_en) exp_d[s] = c;
        else begin
          grp_sum[s] += c;
          grp_n[s]++;
          if (grp_n[s] == (1 << (m_t + 1))) begin
            exp_d[s] = grp_sum[s] >> (m_t + 1);
            grp_sum[s] = 0;
            grp_n[s] = 0;
          end
        end
      end
    end
    if (start) begin
      pend = 3;
      pend_sel = int'(sel);
    end
    if (acq && !acq_prev && log_n < 32) begin
      log_sel[log_n] = int'(sel);
      log_t[log_n] = cyc;
      log_n++;
    end
    if (acq) acq_run++;
    else if (acq_prev) begin
      chk(acq_run == ACQ_F + 1, "R2 acquire length", acq_run, ACQ_F + 1);
      chk(start == 1'b1, "R2 start follows acquire", int'(start), 1);
      acq_run = 0;
    end
    acq_prev = acq;
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    if (a == 8'h0C) begin
      m_en = d[2];
      m_t = int'(d[1:0]);
      for (int s = 0; s < 4; s++) begin grp_sum[s] = 0; grp_n[s] = 0; end
    end
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_log(input int n);
    while (log_n < n) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    for (int s = 0; s < 4; s++) begin conv_n[s] = 0; exp_d[s] = 0; grp_sum[s] = 0; grp_n[s] = 0; end
    idle(3);
    rst_n = 1'b1;
    // R1 / R6: reset state
    for (int w = 0; w < 10; w++) begin
      rd(8'(w * 4), rv);
      chk(rv == 0, "R1 R6 reset read", int'(rv), 0);
    end
    chk(!acq && !start && !irq, "R1 outputs low", int'({acq, start, irq}), 0);

    // R12: programming and readback
    wr(8'h00, (SLOT_F << 16) | ACQ_F);
    wr(8'h08, PER_F << 12);
    wr(8'h10, 32'hF);
    rd(8'h00, rv); chk(rv == ((SLOT_F << 16) | ACQ_F), "R12 control readback", int'(rv), (SLOT_F << 16) | ACQ_F);
    rd(8'h08, rv); chk(rv == (PER_F << 12), "R12 period readback", int'(rv), PER_F << 12);
    rd(8'h10, rv); chk(rv == 32'hF, "R12 irq enable readback", int'(rv), 15);
    rd(8'hFC, rv); chk(rv == 0, "R12 unmapped reads zero", int'(rv), 0);

    // R4 / R7: one sensor, raw storage, round spacing
    log_n = 0;
    wr(8'h04, 32'h1);
    rd(8'h04, rv); chk(rv == 32'h1, "R12 enable readback", int'(rv), 1);
    wait_log(3);
    chk(log_t[2] - log_t[1] == ROUND, "R4 round interval", log_t[2] - log_t[1], ROUND);
    idle(20);
    wr(8'h04, 32'h0);
    idle(40);
    rd(8'h20, rv); chk(rv == exp_d[0], "R7 raw code stored", int'(rv), exp_d[0]);
    rd(8'h24, rv); chk(rv == 0, "R6 unconverted sensor reads zero", int'(rv), 0);
    rd(8'h14, rv); chk(rv == 32'h1, "R10 sticky status after several results", int'(rv), 1);
    chk(irq == 1'b1, "R11 irq with status and enable", int'(irq), 1);

    // R9 / R10: clearing
    wr(8'h14, 32'h0);
    rd(8'h14, rv); chk(rv == 32'h1, "R9 writing zero has no effect", int'(rv), 1);
    wr(8'h14, 32'h1);
    rd(8'h14, rv); chk(rv == 0, "R10 single clear leaves zero", int'(rv), 0);
    chk(irq == 1'b0, "R11 irq drops after clear", int'(irq), 0);

    // R3 / R5: all sensors, order and slot spacing
    log_n = 0;
    wr(8'h04, 32'hF);
    wait_log(4);
    idle(30);
    wr(8'h04, 32'h0);
    idle(60);
    for (int i = 0; i < 4; i++)
      chk(log_sel[i] == i, "R5 ascending order", log_sel[i], i);
    for (int i = 1; i < 4; i++)
      chk(log_t[i] - log_t[i-1] == SLOT_F + 1, "R3 slot spacing", log_t[i] - log_t[i-1], SLOT_F + 1);
    for (int s = 0; s < 4; s++) begin
      rd(8'(8'h20 + s * 4), rv);
      chk(rv == exp_d[s], "R7 per-sensor data", int'(rv), exp_d[s]);
    end
    rd(8'h14, rv); chk(rv == 32'hF, "R9 all status bits set", int'(rv), 15);

    // R5: skipping disabled sensors
    rd(8'h24, keep1);
    wr(8'h14, 32'hF);
    log_n = 0;
    wr(8'h04, 32'h5);
    wait_log(4);
    idle(30);
    wr(8'h04, 32'h0);
    idle(60);
    for (int i = 0; i < 4; i++)
      chk(log_sel[i] == ((i % 2) * 2), "R5 disabled sensors skipped", log_sel[i], (i % 2) * 2);
    rd(8'h24, rv); chk(rv == keep1, "R5 disabled data kept", int'(rv), int'(keep1));
    rd(8'h14, rv); chk(rv == 32'h5, "R5 R9 status only for enabled", int'(rv), 5);
    rd(8'h28, rv); chk(rv == exp_d[2], "R7 sensor 2 data", int'(rv), exp_d[2]);

    // R8: averaging over 4 on sensor 0
    wr(8'h0C, 32'h5);
    rd(8'h0C, rv); chk(rv == 32'h5, "R12 filter readback", int'(rv), 5);
    wr(8'h14, 32'hF);
    log_n = 0;
    wr(8'h04, 32'h1);
    wait_log(3);
    idle(15);
    rd(8'h14, rv); chk(rv == 0, "R8 no result mid-group", int'(rv), 0);
    wait_log(4);
    idle(15);
    wr(8'h04, 32'h0);
    rd(8'h14, rv); chk(rv == 32'h1, "R8 result at group end", int'(rv), 1);
    rd(8'h20, rv); chk(rv == exp_d[0], "R8 four-sample average", int'(rv), exp_d[0]);
    idle(40);

    // R8: averaging over 2 on sensor 2
    wr(8'h0C, 32'h4);
    wr(8'h14, 32'hF);
    log_n = 0;
    wr(8'h04, 32'h4);
    wait_log(1);
    idle(15);
    rd(8'h14, rv); chk(rv == 0, "R8 two-sample group pending", int'(rv), 0);
    wait_log(2);
    idle(15);
    wr(8'h04, 32'h0);
    rd(8'h14, rv); chk(rv == 32'h4, "R8 two-sample group done", int'(rv), 4);
    rd(8'h28, rv); chk(rv == exp_d[2], "R8 two-sample average", int'(rv), exp_d[2]);
    idle(40);

    // R11: enable masking
    wr(8'h10, 32'h1);
    chk(irq == 1'b0, "R11 masked status", int'(irq), 0);
    wr(8'h10, 32'h4);
    chk(irq == 1'b1, "R11 unmasked status", int'(irq), 1);
    wr(8'h10, 32'h0);
    chk(irq == 1'b0, "R11 all masked", int'(irq), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule